// File: doc/BRIEF.md
# Costas Carrier Recovery Controller with Sweep Acquisition

This block steers the local oscillator of a QPSK receiver. Each time a baseband symbol pair (I, Q) arrives with its valid strobe, the block forms a decision-directed Costas phase error. That error feeds a proportional-plus-integral loop filter. The block outputs a signed frequency word that sets the phase increment of the oscillator. The oscillator, mixers and channel filters sit outside the block.

While the block is not locked, a triangle sweep moves a frequency offset across a programmable uncertainty range. The offset changes by a fixed step on every symbol and turns around at each limit. A lock detector sums a per-symbol quadrature-balance score over a fixed window of symbols and applies two thresholds, so the lock state has hysteresis. While locked, the sweep stops and the integrator tracks. If lock is lost, the integrator freezes and the sweep continues from where it stopped. The lock flag also serves as the receiver's data-valid indication.

Top module: `costas_carrier_ctrl`

## Requirements
- R1: In reset, and on the first cycle after it, `freq_word` is 0 and `carrier_lock` is 0. The sweep restarts at offset 0 and first moves upward.
- R2: The phase error is e = s(I)·Q − s(Q)·I, where s(x) = −1 if x < 0 and +1 otherwise. Every valid symbol loads the proportional term e·2^KP_SH, clamped to the FW-bit signed range.
- R3: While unlocked, each valid symbol moves the sweep offset by SWEEP_STEP in its current direction. If a step would reach or pass a limit, the offset is set to that limit and the direction reverses.
- R4: While `carrier_lock` is 1, the sweep offset does not change.
- R5: While locked, each valid symbol adds e·2^KI_SH to the integrator, clamped to the FW-bit signed range. While unlocked, the integrator keeps its value.
- R6: Each valid symbol scores 2^(W_SAMP−1) − ||I|−|Q||. The scores are summed over windows of LOCK_WIN valid symbols. At the end of a window, an unlocked block becomes locked if the sum is greater than LOCK_HI.
- R7: At the end of a window, a locked block becomes unlocked if the sum is less than LOCK_LO. A sum between the two thresholds leaves the state as it is. `carrier_lock` changes only on the clock edge that closes a window.
- R8: `freq_word` equals the clamped sum of sweep offset, integrator and proportional term. It changes only on clock edges where `sym_valid` is 1.
- R9: After lock is lost, the sweep resumes from the offset it held and continues in the direction it had when it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Strobe marking a new I/Q symbol |
| sym_i | input | W_SAMP | In-phase sample, signed |
| sym_q | input | W_SAMP | Quadrature sample, signed |
| freq_word | output | FW | Signed phase increment for the oscillator |
| carrier_lock | output | 1 | Lock flag and data-valid indication |

## Verification
The bench builds the block with 8-bit samples, a 16-bit frequency word, sweep limits of ±300 with a step of 100, a window of 4 symbols and thresholds of 200 and 400. With these values a full sweep period takes a dozen symbols, and a lock decision comes every four symbols. Acquisition, hysteresis, lock loss and the resumed sweep all occur within a few dozen symbols. A grid of I/Q values covering all four quadrants, the zero axes and the most negative code is then run against an arithmetic model of the whole loop.

// File: rtl/costas_pkg.sv
package costas_pkg;

    typedef enum logic {
        SWEEP_DN = 1'b0,
        SWEEP_UP = 1'b1
    } sweep_dir_e;

    // Clamp a value into the signed range of an fw-bit word
    function automatic int clamp_fw(input int v, input int fw);
        int hi;
        int lo;
        hi = (1 << (fw - 1)) - 1;
        lo = -(1 << (fw - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int mag(input int v);
        return (v < 0) ? -v : v;
    endfunction

endpackage

// File: rtl/costas_phase_det.sv
module costas_phase_det #(
    parameter int W_SAMP = 8,
    localparam int EW = W_SAMP + 2
) (
    input  logic signed [W_SAMP-1:0] sym_i,
    input  logic signed [W_SAMP-1:0] sym_q,
    output logic signed [EW-1:0]     err
);
    int term_i;
    int term_q;

    always_comb begin
        // sign(I)*Q and sign(Q)*I, with sign(0) taken as +1
        term_i = sym_i[W_SAMP-1] ? -int'(sym_q) : int'(sym_q);
        term_q = sym_q[W_SAMP-1] ? -int'(sym_i) : int'(sym_i);
        err    = EW'(term_i - term_q);
    end
endmodule

// File: rtl/costas_sweep.sv
module costas_sweep
    import costas_pkg::*;
#(
    parameter int FW         = 18,
    parameter int SWEEP_STEP = 64,
    parameter int SWEEP_LO   = -20000,
    parameter int SWEEP_HI   = 20000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 advance,
    output logic signed [FW-1:0] offset
);
    sweep_dir_e dir;
    int         cur;

    assign cur = int'(offset);

    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= '0;
            dir    <= SWEEP_UP;
        end else if (advance) begin
            if (dir == SWEEP_UP) begin
                if (cur + SWEEP_STEP >= SWEEP_HI) begin
                    offset <= FW'(SWEEP_HI);
                    dir    <= SWEEP_DN;
                end else begin
                    offset <= FW'(cur + SWEEP_STEP);
                end
            end else begin
                if (cur - SWEEP_STEP <= SWEEP_LO) begin
                    offset <= FW'(SWEEP_LO);
                    dir    <= SWEEP_UP;
                end else begin
                    offset <= FW'(cur - SWEEP_STEP);
                end
            end
        end
    end

    // R3: the offset never leaves the programmed range
    p_offset_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(offset) >= SWEEP_LO) && (int'(offset) <= SWEEP_HI));

    // R4: with no advance request the offset holds
    p_offset_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(offset));
endmodule

// File: rtl/costas_lock_det.sv
module costas_lock_det
    import costas_pkg::*;
#(
    parameter int W_SAMP   = 8,
    parameter int LOCK_WIN = 64,
    parameter int LOCK_HI  = 6000,
    parameter int LOCK_LO  = 4000,
    localparam int AMAX  = 1 << (W_SAMP - 1),
    localparam int CNT_W = (LOCK_WIN > 1) ? $clog2(LOCK_WIN) : 1,
    localparam int ACC_W = $clog2(LOCK_WIN * (AMAX + 1) + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sym_valid,
    input  logic signed [W_SAMP-1:0] sym_i,
    input  logic signed [W_SAMP-1:0] sym_q,
    output logic                     locked
);
    logic [CNT_W-1:0] cnt;
    logic [ACC_W-1:0] acc;
    logic             win_end;
    int               score;
    int               total;

    always_comb begin
        score   = AMAX - mag(mag(int'(sym_i)) - mag(int'(sym_q)));
        total   = int'(acc) + score;
        win_end = sym_valid && (cnt == CNT_W'(LOCK_WIN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            acc    <= '0;
            locked <= 1'b0;
        end else if (sym_valid) begin
            if (win_end) begin
                cnt <= '0;
                acc <= '0;
                if (!locked && total > LOCK_HI) locked <= 1'b1;
                else if (locked && total < LOCK_LO) locked <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
                acc <= ACC_W'(total);
            end
        end
    end

    // R7: the lock state moves only on a window boundary
    p_lock_window_only_r7: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(locked));
endmodule

// File: rtl/costas_loop_filter.sv
module costas_loop_filter
    import costas_pkg::*;
#(
    parameter int FW     = 18,
    parameter int EW     = 10,
    parameter int KP_SH  = 3,
    parameter int KI_SH  = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sym_valid,
    input  logic                 locked,
    input  logic signed [EW-1:0] err,
    output logic signed [FW-1:0] integ,
    output logic signed [FW-1:0] prop
);
    int prop_n;
    int integ_n;

    always_comb begin
        prop_n  = clamp_fw(int'(err) * (1 << KP_SH), FW);
        integ_n = clamp_fw(int'(integ) + int'(err) * (1 << KI_SH), FW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ <= '0;
            prop  <= '0;
        end else if (sym_valid) begin
            prop <= FW'(prop_n);
            if (locked) integ <= FW'(integ_n);
        end
    end

    // R5: the integrator is frozen unless a symbol arrives while locked
    p_integ_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(sym_valid && locked) |=> $stable(integ));
endmodule

// File: rtl/costas_carrier_ctrl.sv
module costas_carrier_ctrl
    import costas_pkg::*;
#(
    parameter int W_SAMP     = 8,
    parameter int FW         = 18,
    parameter int KP_SH      = 3,
    parameter int KI_SH      = 0,
    parameter int SWEEP_STEP = 64,
    parameter int SWEEP_LO   = -20000,
    parameter int SWEEP_HI   = 20000,
    parameter int LOCK_WIN   = 64,
    parameter int LOCK_HI    = 6000,
    parameter int LOCK_LO    = 4000,
    localparam int EW = W_SAMP + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sym_valid,
    input  logic signed [W_SAMP-1:0] sym_i,
    input  logic signed [W_SAMP-1:0] sym_q,
    output logic signed [FW-1:0]     freq_word,
    output logic                     carrier_lock
);
    logic signed [EW-1:0] err;
    logic signed [FW-1:0] offset;
    logic signed [FW-1:0] integ;
    logic signed [FW-1:0] prop;

    costas_phase_det #(.W_SAMP(W_SAMP)) u_pd (
        .sym_i(sym_i), .sym_q(sym_q), .err(err)
    );

    costas_sweep #(
        .FW(FW), .SWEEP_STEP(SWEEP_STEP), .SWEEP_LO(SWEEP_LO), .SWEEP_HI(SWEEP_HI)
    ) u_sweep (
        .clk(clk), .rst(rst), .advance(sym_valid && !carrier_lock), .offset(offset)
    );

    costas_loop_filter #(
        .FW(FW), .EW(EW), .KP_SH(KP_SH), .KI_SH(KI_SH)
    ) u_lf (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .locked(carrier_lock),
        .err(err), .integ(integ), .prop(prop)
    );

    costas_lock_det #(
        .W_SAMP(W_SAMP), .LOCK_WIN(LOCK_WIN), .LOCK_HI(LOCK_HI), .LOCK_LO(LOCK_LO)
    ) u_ld (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
        .locked(carrier_lock)
    );

    assign freq_word = FW'(clamp_fw(int'(offset) + int'(integ) + int'(prop), FW));

    // R8: with no symbol the frequency word holds
    p_freq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> $stable(freq_word));

    // R4: while locked the sweep contributes no motion
    p_sweep_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        carrier_lock |=> $stable(offset));
endmodule

// File: tb/tb_costas_carrier_ctrl.sv
module tb_costas_carrier_ctrl;
    localparam int W    = 8;
    localparam int FW   = 16;
    localparam int KP   = 2;
    localparam int KI   = 1;
    localparam int STEP = 100;
    localparam int LO   = -300;
    localparam int HI   = 300;
    localparam int WIN  = 4;
    localparam int THI  = 400;
    localparam int TLO  = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_valid = 1'b0;
    logic signed [W-1:0] sym_i = '0;
    logic signed [W-1:0] sym_q = '0;
    logic signed [FW-1:0] freq_word;
    logic carrier_lock;

    int n_checks = 0;
    int n_errs   = 0;

    // model state
    int m_off, m_dir, m_integ, m_prop, m_acc, m_cnt, m_lock;

    always #5 clk = ~clk;

    costas_carrier_ctrl #(
        .W_SAMP(W), .FW(FW), .KP_SH(KP), .KI_SH(KI), .SWEEP_STEP(STEP),
        .SWEEP_LO(LO), .SWEEP_HI(HI), .LOCK_WIN(WIN), .LOCK_HI(THI), .LOCK_LO(TLO)
    ) dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
        .freq_word(freq_word), .carrier_lock(carrier_lock)
    );

    function automatic int clampf(input int v);
        int h;
        h = (1 << (FW - 1)) - 1;
        if (v > h) return h;
        if (v < -h - 1) return -h - 1;
        return v;
    endfunction

    function automatic int absv(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic model_reset();
        m_off = 0; m_dir = 1; m_integ = 0; m_prop = 0;
        m_acc = 0; m_cnt = 0; m_lock = 0;
    endtask

    task automatic model_sym(input int i, input int q);
        int e, sc, tot;
        e  = ((i < 0) ? -q : q) - ((q < 0) ? -i : i);
        sc = (1 << (W - 1)) - absv(absv(i) - absv(q));
        m_prop = clampf(e * (1 << KP));
        if (m_lock != 0) begin
            m_integ = clampf(m_integ + e * (1 << KI));
        end else if (m_dir == 1) begin
            if (m_off + STEP >= HI) begin m_off = HI; m_dir = 0; end
            else m_off = m_off + STEP;
        end else begin
            if (m_off - STEP <= LO) begin m_off = LO; m_dir = 1; end
            else m_off = m_off - STEP;
        end
        tot = m_acc + sc;
        if (m_cnt == WIN - 1) begin
            if (m_lock == 0 && tot > THI) m_lock = 1;
            else if (m_lock != 0 && tot < TLO) m_lock = 0;
            m_acc = 0; m_cnt = 0;
        end else begin
            m_acc = tot; m_cnt = m_cnt + 1;
        end
    endtask

    task automatic check(input string tag);
        int expf;
        expf = clampf(m_off + m_integ + m_prop);
        n_checks++;
        if (int'(freq_word) != expf || int'(carrier_lock) != m_lock) begin
            n_errs++;
            $display("FAIL %s: freq_word=%0d lock=%0d expected freq_word=%0d lock=%0d",
                     tag, freq_word, carrier_lock, expf, m_lock);
        end
    endtask

    // called at a negative edge; returns at the next negative edge
    task automatic step(input logic v, input int i, input int q, input string tag);
        sym_valid = v;
        sym_i = W'(i);
        sym_q = W'(q);
        @(posedge clk);
        if (v) model_sym(i, q);
        #2;
        check(tag);
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sym_valid = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        check("R1 in reset");
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1 after reset");
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R3: unlocked sweep, low score keeps it unlocked; covers both reversals
        for (int k = 0; k < 12; k++) step(1'b1, 100, 0, "R3 sweep triangle");

        // R8: idle cycles leave everything unchanged
        for (int k = 0; k < 3; k++) step(1'b0, 77, -55, "R8 idle hold");

        // R6: balanced symbols produce a high window score and lock
        for (int k = 0; k < 4; k++) step(1'b1, 50, 50, "R6 acquire lock");

        // R4 and R5: locked tracking, sweep frozen, integrator moving
        for (int k = 0; k < 8; k++) step(1'b1, 60, 40, "R4 R5 locked tracking");
        for (int k = 0; k < 4; k++) step(1'b1, -70, 20, "R5 integrator other sign");

        // R7: score between thresholds keeps lock
        for (int k = 0; k < 4; k++) step(1'b1, 100, 30, "R7 hysteresis hold locked");

        // R7: low score drops lock
        for (int k = 0; k < 4; k++) step(1'b1, 100, 0, "R7 drop lock");

        // R9 and R5: sweep resumes from held offset, integrator frozen
        for (int k = 0; k < 8; k++) step(1'b1, 100, 30, "R9 sweep resumes");

        // R2: grid across quadrants, axes and most negative code
        for (int a = -128; a < 128; a += 37) begin
            for (int b = -128; b < 128; b += 37) begin
                step(1'b1, a, b, "R2 phase error grid");
            end
        end
        for (int k = 0; k < 4; k++) step(1'b1, 0, 0, "R2 zero sign rule");
        for (int k = 0; k < 4; k++) step(1'b1, -128, 0, "R2 extreme code");

        // R1: reset mid-run restores the initial state
        do_reset();
        step(1'b1, 100, 0, "R1 first step after reset");

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule